// File: doc/BRIEF.md
# Arithmetic Exception Reporting Unit

This unit sits at the tail of a processor's execute stage. Each cycle that the execute stage presents a finished instruction, it also presents the arithmetic conditions that the instruction raised, its start address and its decoded byte length. The unit decides whether an arithmetic exception must be taken and picks one condition when several are raised together. It produces the 4-bit type code for that condition and marks it as either a trap or a restartable fault.

The class sets the saved program counter and the commit behaviour. A trap commits the instruction's results and saves the address of the following instruction. A fault suppresses write-back and saves the address of the faulting instruction, so the instruction can be restarted after the handler has repaired the cause.

The unit also loads the following-instruction address into a readable register on every exception, faults included. A handler that decides not to restart can therefore resume past the instruction without decoding its length. A compatibility input makes every floating condition report as a trap with its older type code.

Top module: `arith_exc_unit`

## Requirements
- R1: `exc_valid` is high in the clock cycle that follows an `in_valid` strobe whose conditions raise an exception, and is low in every other cycle.
- R2: The condition bits of `in_cond` are: bit 0 integer overflow, bit 1 integer divide-by-zero, bit 2 decimal divide-by-zero, bit 3 decimal overflow, bit 4 subscript range. These always report as traps (`exc_fault` = 0) with codes 1, 2, 4, 6 and 7 respectively.
- R3: Bit 5 floating overflow, bit 6 floating divide-by-zero and bit 7 floating underflow report as faults (`exc_fault` = 1) with codes 8, 9 and 10 when `legacy_mode` is 0.
- R4: For a trap, `saved_pc` equals `in_pc + in_len`, taken modulo 2^PC_W.
- R5: For a fault, `saved_pc` equals `in_pc`, and `wb_inhibit` is high in the cycle that the fault is reported. `wb_inhibit` is low in every other cycle, including every cycle in which a trap is reported.
- R6: When `fu_en` is 0, a raised floating-underflow bit is ignored. If it is the only bit raised, no exception is reported.
- R7: When `legacy_mode` is 1, floating overflow, floating divide-by-zero and floating underflow report as traps with codes 3, 4 and 5. In that mode they save the next-instruction address and leave `wb_inhibit` low.
- R8: On every reported exception, trap or fault, `next_pc` is loaded with `in_pc + in_len` modulo 2^PC_W.
- R9: When several enabled conditions are raised together, a single condition is reported. The groups rank divide-by-zero first, then overflow, then underflow, then subscript range. Inside a group, the integer condition wins over the decimal condition, and the decimal condition wins over the floating condition.
- R10: A strobe that raises no exception leaves `exc_code`, `exc_fault`, `saved_pc` and `next_pc` unchanged.
- R11: While `rst_n` is low, `exc_valid`, `wb_inhibit` and `next_pc` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | A finished instruction is presented this cycle |
| in_pc | input | PC_W | Start address of the instruction |
| in_len | input | LEN_W | Instruction length in bytes (1 to 31) |
| in_cond | input | 8 | Raised arithmetic conditions, bit map in R2 and R3 |
| fu_en | input | 1 | Floating-underflow reporting enable from the status word |
| legacy_mode | input | 1 | Report floating conditions as traps with the older codes |
| exc_valid | output | 1 | An exception is reported this cycle |
| exc_code | output | 4 | Type code of the reported exception |
| exc_fault | output | 1 | 1 = restartable fault, 0 = trap |
| saved_pc | output | PC_W | Program counter to be saved for the handler |
| next_pc | output | PC_W | Address of the instruction after the excepting one |
| wb_inhibit | output | 1 | Block result write-back of the excepting instruction |

## Verification
The bench builds the unit with PC_W = 16 and the default LEN_W = 5. A 16-bit address space lets start addresses near the top of the range overflow when the length is added, so the modular address arithmetic is exercised routinely. The sweep covers every one of the 256 condition patterns under all four combinations of underflow enable and legacy mode. It therefore reaches every priority collision, every masked-underflow case and every legacy recoding. An asynchronous reset in the middle of the sweep checks that the next-address register clears and that later exceptions reload it.

// File: rtl/arith_exc_pkg.sv
package arith_exc_pkg;

  localparam int NCOND  = 8;
  localparam int CODE_W = 4;

  // condition bit positions on the input vector
  localparam int C_INT_OVF = 0;
  localparam int C_INT_DVZ = 1;
  localparam int C_DEC_DVZ = 2;
  localparam int C_DEC_OVF = 3;
  localparam int C_SUBRNG  = 4;
  localparam int C_FLT_OVF = 5;
  localparam int C_FLT_DVZ = 6;
  localparam int C_FLT_UND = 7;

  typedef logic [CODE_W-1:0] code_t;

  // condition examined at a given rank, rank 0 winning
  function automatic int rank_to_cond(input int rank);
    case (rank)
      0:       return C_INT_DVZ;
      1:       return C_DEC_DVZ;
      2:       return C_FLT_DVZ;
      3:       return C_INT_OVF;
      4:       return C_DEC_OVF;
      5:       return C_FLT_OVF;
      6:       return C_FLT_UND;
      default: return C_SUBRNG;
    endcase
  endfunction

  function automatic code_t cond_code(input int idx, input logic legacy);
    case (idx)
      C_INT_OVF: return code_t'(1);
      C_INT_DVZ: return code_t'(2);
      C_DEC_DVZ: return code_t'(4);
      C_DEC_OVF: return code_t'(6);
      C_SUBRNG:  return code_t'(7);
      C_FLT_OVF: return legacy ? code_t'(3) : code_t'(8);
      C_FLT_DVZ: return legacy ? code_t'(4) : code_t'(9);
      default:   return legacy ? code_t'(5) : code_t'(10);
    endcase
  endfunction

  function automatic logic cond_is_fault(input int idx, input logic legacy);
    return (idx >= C_FLT_OVF) && !legacy;
  endfunction

endpackage

// File: rtl/arith_exc_prio.sv
module arith_exc_prio
  import arith_exc_pkg::*;
(
  input  logic [NCOND-1:0] cond,
  input  logic             fu_en,
  output logic [NCOND-1:0] sel,
  output logic             any
);

  logic [NCOND-1:0] enabled;

  always_comb begin
    enabled = cond;
    if (!fu_en) enabled[C_FLT_UND] = 1'b0;
  end

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int r = 0; r < NCOND; r++) begin
      if (enabled[rank_to_cond(r)] && !any) begin
        sel[rank_to_cond(r)] = 1'b1;
        any = 1'b1;
      end
    end
  end

  // R9
  always_comb begin
    single_sel_chk: assert ($onehot0(sel));
  end

  // R6
  always_comb begin
    masked_und_chk: assert (fu_en || !sel[C_FLT_UND]);
  end

endmodule

// File: rtl/arith_exc_classify.sv
module arith_exc_classify
  import arith_exc_pkg::*;
(
  input  logic [NCOND-1:0] sel,
  input  logic             legacy,
  output code_t            code,
  output logic             fault
);

  always_comb begin
    code  = '0;
    fault = 1'b0;
    for (int i = 0; i < NCOND; i++) begin
      if (sel[i]) begin
        code  = code | cond_code(i, legacy);
        fault = fault | cond_is_fault(i, legacy);
      end
    end
  end

  // R7
  always_comb begin
    legacy_trap_chk: assert (!(legacy && fault));
  end

endmodule

// File: rtl/arith_exc_unit.sv
module arith_exc_unit
  import arith_exc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [NCOND-1:0]  in_cond,
  input  logic              fu_en,
  input  logic              legacy_mode,
  output logic              exc_valid,
  output logic [CODE_W-1:0] exc_code,
  output logic              exc_fault,
  output logic [PC_W-1:0]   saved_pc,
  output logic [PC_W-1:0]   next_pc,
  output logic              wb_inhibit
);

  localparam int ADD_W = (PC_W > LEN_W) ? PC_W : LEN_W;

  logic [NCOND-1:0] sel;
  logic             any;
  code_t            code_c;
  logic             fault_c;
  logic             raise;
  logic [PC_W-1:0]  follow_pc;
  logic [ADD_W-1:0] sum_w;

  logic             valid_d, inhib_d;
  logic [PC_W-1:0]  next_d, saved_d;
  logic             valid_q, inhib_q, fault_q;
  logic [PC_W-1:0]  next_q, saved_q;
  code_t            code_q;

  arith_exc_prio u_prio (
    .cond  (in_cond),
    .fu_en (fu_en),
    .sel   (sel),
    .any   (any)
  );

  arith_exc_classify u_class (
    .sel    (sel),
    .legacy (legacy_mode),
    .code   (code_c),
    .fault  (fault_c)
  );

  // next-state logic
  always_comb begin
    sum_w     = ADD_W'(in_pc) + ADD_W'(in_len);
    follow_pc = sum_w[PC_W-1:0];
    raise     = in_valid && any;
    valid_d   = raise;
    inhib_d   = raise && fault_c;
    next_d    = raise ? follow_pc : next_q;
    saved_d   = fault_c ? in_pc : follow_pc;
  end

  // control registers and the readable next-address register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      inhib_q <= 1'b0;
      next_q  <= '0;
    end else begin
      valid_q <= valid_d;
      inhib_q <= inhib_d;
      next_q  <= next_d;
    end
  end

  // datapath registers, loaded only when an exception is raised
  always_ff @(posedge clk) begin
    if (raise) begin
      code_q  <= code_c;
      fault_q <= fault_c;
      saved_q <= saved_d;
    end
  end

  assign exc_valid  = valid_q;
  assign exc_code   = code_q;
  assign exc_fault  = fault_q;
  assign saved_pc   = saved_q;
  assign next_pc    = next_q;
  assign wb_inhibit = inhib_q;

  // R1
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(in_valid));

  // R5
  fault_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_fault) |-> (saved_pc == $past(in_pc)));

  // R4
  trap_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_fault) |-> (saved_pc == next_pc));

  // R5
  inhibit_only_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_inhibit |-> (exc_valid && exc_fault));

  // R7
  legacy_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && $past(legacy_mode)) |-> !exc_fault);

  // R3
  fault_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_fault) |-> (exc_code >= code_t'(8)));

  // R10
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any) |=> ($stable(saved_pc) && $stable(next_pc)));

endmodule

// File: tb/test_arith_exc_unit.sv
module test_arith_exc_unit;

  localparam int PC_W  = 16;
  localparam int LEN_W = 5;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [PC_W-1:0]  in_pc;
  logic [LEN_W-1:0] in_len;
  logic [7:0]       in_cond;
  logic             fu_en;
  logic             legacy_mode;
  logic             exc_valid;
  logic [3:0]       exc_code;
  logic             exc_fault;
  logic [PC_W-1:0]  saved_pc;
  logic [PC_W-1:0]  next_pc;
  logic             wb_inhibit;

  int n_cmp;
  int n_bad;
  bit done;

  arith_exc_unit #(.PC_W(PC_W), .LEN_W(LEN_W)) i_arith_exc_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_pc       (in_pc),
    .in_len      (in_len),
    .in_cond     (in_cond),
    .fu_en       (fu_en),
    .legacy_mode (legacy_mode),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code),
    .exc_fault   (exc_fault),
    .saved_pc    (saved_pc),
    .next_pc     (next_pc),
    .wb_inhibit  (wb_inhibit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference choice of the reported condition, -1 when none
  function automatic int pick(input logic [7:0] f, input bit fu);
    int ord [8] = '{1, 2, 6, 0, 3, 5, 7, 4};
    logic [7:0] m;
    m = f;
    if (!fu) m[7] = 1'b0;
    for (int r = 0; r < 8; r++)
      if (m[ord[r]]) return ord[r];
    return -1;
  endfunction

  function automatic int ref_code(input int idx, input bit leg);
    int trap_tab [8] = '{1, 2, 4, 6, 7, 3, 4, 5};
    if (idx >= 5 && !leg) return idx + 3;
    return trap_tab[idx];
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] exp_saved, exp_next, nxt;
    logic [3:0]      exp_code;
    bit              exp_fault, have_data;
    int              idx;
    n_cmp = 0; n_bad = 0; done = 0;
    have_data = 0;
    exp_saved = '0; exp_code = '0; exp_fault = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_pc = '0; in_len = '0;
    in_cond = '0; fu_en = 1'b0; legacy_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 exc_valid", 32'(exc_valid), 0);
    chk("R11 wb_inhibit", 32'(wb_inhibit), 0);
    chk("R11 next_pc", 32'(next_pc), 0);
    rst_n = 1'b1;
    exp_next = '0;
    @(negedge clk);

    for (int c = 0; c < 1024; c++) begin
      in_cond     = c[7:0];
      fu_en       = c[8];
      legacy_mode = c[9];
      in_pc       = PC_W'(16'hFFE0 + c * 37);
      in_len      = LEN_W'((c * 13) % 31 + 1);
      in_valid    = 1'b1;
      idx = pick(in_cond, fu_en);
      nxt = in_pc + PC_W'(in_len);
      @(negedge clk);
      in_valid = 1'b0;
      if (idx >= 0) begin
        exp_code  = 4'(ref_code(idx, legacy_mode));
        exp_fault = (idx >= 5) && !legacy_mode;
        exp_saved = exp_fault ? in_pc : nxt;
        exp_next  = nxt;
        have_data = 1;
        chk("R1 exc_valid raised", 32'(exc_valid), 1);
        chk("R9 R2 R3 R7 exc_code", 32'(exc_code), 32'(exp_code));
        chk("R2 R3 R7 exc_fault", 32'(exc_fault), 32'(exp_fault));
        if (exp_fault) chk("R5 saved_pc fault", 32'(saved_pc), 32'(exp_saved));
        else           chk("R4 saved_pc trap", 32'(saved_pc), 32'(exp_saved));
        chk("R8 next_pc", 32'(next_pc), 32'(exp_next));
        chk("R5 wb_inhibit", 32'(wb_inhibit), 32'(exp_fault));
      end else begin
        // R6 masked underflow / no condition
        chk("R1 R6 exc_valid quiet", 32'(exc_valid), 0);
        chk("R5 wb_inhibit quiet", 32'(wb_inhibit), 0);
        chk("R10 next_pc hold", 32'(next_pc), 32'(exp_next));
        if (have_data) begin
          chk("R10 saved_pc hold", 32'(saved_pc), 32'(exp_saved));
          chk("R10 exc_code hold", 32'(exc_code), 32'(exp_code));
          chk("R10 exc_fault hold", 32'(exc_fault), 32'(exp_fault));
        end
      end
      if (c % 64 == 63) begin
        @(negedge clk);
        chk("R1 idle exc_valid", 32'(exc_valid), 0);
        chk("R5 idle wb_inhibit", 32'(wb_inhibit), 0);
        chk("R10 idle next_pc", 32'(next_pc), 32'(exp_next));
      end
      if (c == 517) begin
        rst_n = 1'b0;
        #1;
        chk("R11 mid reset next_pc", 32'(next_pc), 0);
        chk("R11 mid reset exc_valid", 32'(exc_valid), 0);
        chk("R11 mid reset wb_inhibit", 32'(wb_inhibit), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_next = '0;
        @(negedge clk);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule